// File: doc/BRIEF.md
# Finished Load Buffer Violation Checker

This block holds loads that executed speculatively ahead of older stores. Each load enters when it finishes and leaves when it completes. Loads enter and leave in program order, so the storage is a circular queue. When a store completes, its address is compared against every load still held. A held load conflicts with the store when the load is younger than the store and reads the same address. Such a load read stale memory, so it and everything after it must be re-executed.

On a conflict the block emits a one-cycle violation pulse carrying the sequence tag of the oldest conflicting load. In the same clock edge it discards that entry and every younger one. A flush empties the queue. When the queue is full, a ready signal goes low and new load finishes are held back. The block does not start any refetch; it only reports which load must be replayed.

Sequence tags are one bit wider than the reorder-buffer index. This lets age be compared correctly after the tag counter wraps around.

Top module: `flb_viol_chk`

## Requirements
- R1: After reset the queue is empty, `ld_fin_ready_o` is 1 and `viol_o` is 0.
- R2: When a completing store matches a held load, `viol_o` is 1 in the cycle after the store-complete cycle. In that cycle `viol_seq_o` carries the tag of the reported load.
- R3: A completing store that matches no held load leaves `viol_o` at 0 in the following cycle. This includes the case where the queue is empty.
- R4: A held load counts as a match only if its address is equal to the store's address and it is younger than the store. A load is younger when (load_tag - store_tag) mod 2^SEQ_W is nonzero and less than 2^(SEQ_W-1). Loads with an equal or older tag are ignored.
- R5: When several held loads match, the one allocated earliest is reported.
- R6: A violation removes the reported load and every later entry at the same edge. A load finish presented in that same cycle is discarded.
- R7: A load complete removes the oldest entry. A load complete on an empty queue has no effect.
- R8: The queue holds at most DEPTH loads. `ld_fin_ready_o` is 0 exactly when it is full, and a load finish offered while full is dropped.
- R9: Flush empties the queue at the next edge. In its cycle it suppresses both the store check and any load finish.
- R10: A load completing in the same cycle as a store check is still included in the check. If that load is the one reported, the completion is dropped and the violation removes the load.
- R11: `viol_o` is a single-cycle pulse. It returns to 0 on the next idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_fin_valid_i | input | 1 | A load has finished and asks to be buffered |
| ld_fin_ready_o | output | 1 | Queue can accept a finishing load |
| ld_fin_addr_i | input | ADDR_W | Address of the finishing load |
| ld_fin_seq_i | input | SEQ_W | Sequence tag of the finishing load |
| ld_cmp_i | input | 1 | Oldest buffered load completes |
| flush_i | input | 1 | Discard all buffered loads |
| st_cmp_valid_i | input | 1 | A store completes and must be checked |
| st_cmp_addr_i | input | ADDR_W | Address of the completing store |
| st_cmp_seq_i | input | SEQ_W | Sequence tag of the completing store |
| viol_o | output | 1 | Memory-order violation detected (registered pulse) |
| viol_seq_o | output | SEQ_W | Tag of the oldest offending load |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=16 and a 3-bit reorder index, which gives 4-bit sequence tags. With these values a few load finishes fill the queue, so the full condition and the dropped finish (R8) can be reached. The tags also wrap within a short run, so a load tagged 1 must be seen as younger than a store tagged 15, and a load tagged 14 as older (R4). The head pointer moves around the ring, so oldest-first selection (R5) is tested at positions other than slot 0.

// File: rtl/flb_pkg.sv
package flb_pkg;
  typedef enum logic [1:0] {
    TAIL_HOLD  = 2'd0,
    TAIL_STEP  = 2'd1,
    TAIL_TRUNC = 2'd2,
    TAIL_CLEAR = 2'd3
  } tail_act_e;
endpackage

// File: rtl/flb_entry_ram.sv
module flb_entry_ram #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int SEQ_W  = 7,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SEQ_W-1:0]  wr_seq_i,
  output logic [ADDR_W-1:0] addr_o [DEPTH],
  output logic [SEQ_W-1:0]  seq_o  [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ADDR_W-1:0] addr_q;
    logic [SEQ_W-1:0]  seq_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        seq_q  <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
        addr_q <= wr_addr_i;
        seq_q  <= wr_seq_i;
      end
    end
    assign addr_o[i] = addr_q;
    assign seq_o[i]  = seq_q;
  end
endmodule

// File: rtl/flb_match.sv
module flb_match #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int SEQ_W  = 7
) (
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [SEQ_W-1:0]  st_seq_i,
  input  logic [ADDR_W-1:0] addr_i [DEPTH],
  input  logic [SEQ_W-1:0]  seq_i  [DEPTH],
  output logic [DEPTH-1:0]  hit_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [SEQ_W-1:0] age_diff;
    logic             younger;
    // wrap-aware: positive distance below half the tag space
    assign age_diff = seq_i[i] - st_seq_i;
    assign younger  = (age_diff != '0) && !age_diff[SEQ_W-1];
    assign hit_o[i] = st_valid_i && younger && (addr_i[i] == st_addr_i);
  end
endmodule

// File: rtl/flb_oldest_pick.sv
module flb_oldest_pick #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [DEPTH-1:0] hit_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic [PTR_W-1:0] count_i,
  output logic             any_o,
  output logic [IDX_W-1:0] off_o,
  output logic [DEPTH-1:0] oh_o
);
  logic [DEPTH-1:0] aged;

  // reorder hits by age, masking slots outside the live window
  always_comb begin
    for (int o = 0; o < DEPTH; o++) begin
      aged[o] = hit_i[head_i + IDX_W'(o)] && (PTR_W'(o) < count_i);
    end
  end

  always_comb begin
    any_o = 1'b0;
    off_o = '0;
    oh_o  = '0;
    for (int o = 0; o < DEPTH; o++) begin
      if (aged[o] && !any_o) begin
        any_o = 1'b1;
        off_o = IDX_W'(o);
        oh_o[head_i + IDX_W'(o)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/flb_viol_chk.sv
module flb_viol_chk
  import flb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int ROB_IDX_W = 6,
  localparam int SEQ_W    = ROB_IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_fin_valid_i,
  output logic              ld_fin_ready_o,
  input  logic [ADDR_W-1:0] ld_fin_addr_i,
  input  logic [SEQ_W-1:0]  ld_fin_seq_i,
  input  logic              ld_cmp_i,
  input  logic              flush_i,
  input  logic              st_cmp_valid_i,
  input  logic [ADDR_W-1:0] st_cmp_addr_i,
  input  logic [SEQ_W-1:0]  st_cmp_seq_i,
  output logic              viol_o,
  output logic [SEQ_W-1:0]  viol_seq_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0]  head_q, tail_q, tail_d, count, off_ptr;
  logic              full, st_chk, viol_set, alloc, pop;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [SEQ_W-1:0]  ent_seq  [DEPTH];
  logic [DEPTH-1:0]  hit, pick_oh;
  logic              pick_any;
  logic [IDX_W-1:0]  pick_off;
  logic              viol_q;
  logic [SEQ_W-1:0]  viol_seq_q;
  tail_act_e         tail_act;

  assign count          = tail_q - head_q;
  assign full           = (count == PTR_W'(DEPTH));
  assign ld_fin_ready_o = !full;

  assign st_chk   = st_cmp_valid_i && !flush_i;
  assign viol_set = st_chk && pick_any;
  assign off_ptr  = head_q + PTR_W'(pick_off);
  assign alloc    = ld_fin_valid_i && !full && !flush_i && !viol_set;
  // offender at head cannot also complete
  assign pop      = ld_cmp_i && (count != '0) && !flush_i &&
                    !(viol_set && pick_off == '0);

  flb_entry_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (alloc),
    .wr_idx_i  (tail_q[IDX_W-1:0]),
    .wr_addr_i (ld_fin_addr_i),
    .wr_seq_i  (ld_fin_seq_i),
    .addr_o    (ent_addr),
    .seq_o     (ent_seq)
  );

  flb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_match (
    .st_valid_i (st_chk),
    .st_addr_i  (st_cmp_addr_i),
    .st_seq_i   (st_cmp_seq_i),
    .addr_i     (ent_addr),
    .seq_i      (ent_seq),
    .hit_o      (hit)
  );

  flb_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .hit_i   (hit),
    .head_i  (head_q[IDX_W-1:0]),
    .count_i (count),
    .any_o   (pick_any),
    .off_o   (pick_off),
    .oh_o    (pick_oh)
  );

  always_comb begin
    if (flush_i)       tail_act = TAIL_CLEAR;
    else if (viol_set) tail_act = TAIL_TRUNC;
    else if (alloc)    tail_act = TAIL_STEP;
    else               tail_act = TAIL_HOLD;
    unique case (tail_act)
      TAIL_CLEAR: tail_d = '0;
      TAIL_TRUNC: tail_d = off_ptr;
      TAIL_STEP:  tail_d = tail_q + PTR_W'(1);
      default:    tail_d = tail_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      tail_q <= tail_d;
      if (flush_i)  head_q <= '0;
      else if (pop) head_q <= head_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q     <= 1'b0;
      viol_seq_q <= '0;
    end else begin
      viol_q <= viol_set;
      if (viol_set) viol_seq_q <= ent_seq[off_ptr[IDX_W-1:0]];
    end
  end

  assign viol_o     = viol_q;
  assign viol_seq_o = viol_seq_q;

  p_count_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= PTR_W'(DEPTH));
  p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && ld_fin_valid_i && !flush_i && !viol_set) |=> tail_q == $past(tail_q));
  p_viol_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(st_cmp_valid_i && !flush_i));
  p_trunc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_set |=> tail_q == $past(off_ptr));
  p_empty_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cmp_i && count == '0 && !flush_i) |=> $stable(head_q));
  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count == '0);
  p_one_pick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick_oh));
  p_empty_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_cmp_valid_i && count == '0) |=> !viol_o);
endmodule

// File: tb/flb_viol_chk_tb.sv
module flb_viol_chk_tb;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int RIW   = 3;
  localparam int SW    = RIW + 1;
  localparam int NV    = 16;

  // kind: 0 idle, 1 load finish, 2 load complete, 3 store complete, 4 flush
  // {kind[2:0], addr[15:0], seq[3:0], exp_viol, exp_seq[3:0]}
  localparam logic [27:0] VEC [NV] = '{
    {3'd1, 16'h0010, 4'd2,  1'b0, 4'd0},
    {3'd1, 16'h0020, 4'd3,  1'b0, 4'd0},
    {3'd3, 16'h0030, 4'd1,  1'b0, 4'd0},  // R3 no address match
    {3'd3, 16'h0010, 4'd3,  1'b0, 4'd0},  // R4 older load ignored
    {3'd3, 16'h0020, 4'd1,  1'b1, 4'd3},  // R2
    {3'd3, 16'h0020, 4'd1,  1'b0, 4'd0},  // R6 entry removed
    {3'd1, 16'h0020, 4'd3,  1'b0, 4'd0},
    {3'd1, 16'h0020, 4'd4,  1'b0, 4'd0},
    {3'd3, 16'h0020, 4'd2,  1'b1, 4'd3},  // R5 oldest of two
    {3'd2, 16'h0000, 4'd0,  1'b0, 4'd0},
    {3'd1, 16'h0040, 4'd14, 1'b0, 4'd0},
    {3'd1, 16'h0044, 4'd15, 1'b0, 4'd0},
    {3'd1, 16'h0040, 4'd1,  1'b0, 4'd0},
    {3'd3, 16'h0040, 4'd15, 1'b1, 4'd1},  // R4 wrap
    {3'd4, 16'h0000, 4'd0,  1'b0, 4'd0},
    {3'd3, 16'h0040, 4'd0,  1'b0, 4'd0}   // R9 flushed
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lf_v = 1'b0, lc = 1'b0, fl = 1'b0, st_v = 1'b0;
  logic [AW-1:0] lf_a = '0, st_a = '0;
  logic [SW-1:0] lf_s = '0, st_s = '0;
  logic          ready, viol;
  logic [SW-1:0] viol_seq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  flb_viol_chk #(.DEPTH(DEPTH), .ADDR_W(AW), .ROB_IDX_W(RIW)) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .ld_fin_valid_i (lf_v), .ld_fin_ready_o (ready),
    .ld_fin_addr_i (lf_a), .ld_fin_seq_i (lf_s),
    .ld_cmp_i (lc), .flush_i (fl),
    .st_cmp_valid_i (st_v), .st_cmp_addr_i (st_a), .st_cmp_seq_i (st_s),
    .viol_o (viol), .viol_seq_o (viol_seq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, then check at the next negedge
  task automatic cyc(input logic f, input logic c, input logic s, input logic x,
                     input logic [AW-1:0] la, input logic [SW-1:0] ls,
                     input logic [AW-1:0] sa, input logic [SW-1:0] ss);
    lf_v = f; lc = c; st_v = s; fl = x;
    lf_a = la; lf_s = ls; st_a = sa; st_s = ss;
    @(negedge clk);
    lf_v = 1'b0; lc = 1'b0; st_v = 1'b0; fl = 1'b0;
  endtask

  task automatic expect_viol(input string req, input logic ev, input logic [SW-1:0] es);
    chk(req, 32'(viol), 32'(ev));
    if (ev) chk(req, 32'(viol_seq), 32'(es));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 viol", 32'(viol), 32'd0);
    chk("R1 ready", 32'(ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]    k;
      logic [AW-1:0] a;
      logic [SW-1:0] s;
      k = VEC[i][27:25]; a = VEC[i][24:9]; s = VEC[i][8:5];
      cyc(k == 3'd1, k == 3'd2, k == 3'd3, k == 3'd4, a, s, a, s);
      expect_viol($sformatf("R2-table v%0d", i), VEC[i][4], VEC[i][3:0]);
    end

    // R8 fill to full, drop extra finish
    for (int j = 0; j < DEPTH; j++)
      cyc(1, 0, 0, 0, AW'(16'h0050 + j), SW'(j + 1), '0, '0);
    chk("R8 ready full", 32'(ready), 32'd0);
    cyc(1, 0, 0, 0, 16'h0099, 4'd5, '0, '0);
    cyc(0, 1, 0, 0, '0, '0, '0, '0);
    chk("R7 ready after pop", 32'(ready), 32'd1);
    cyc(0, 0, 1, 0, '0, '0, 16'h0099, 4'd0);
    expect_viol("R8 dropped finish", 1'b0, '0);

    // R10 completing head still checked, completion dropped
    cyc(0, 1, 1, 0, '0, '0, 16'h0051, 4'd1);
    expect_viol("R10 same-cycle complete", 1'b1, 4'd2);
    cyc(0, 0, 0, 0, '0, '0, '0, '0);
    chk("R11 pulse ends", 32'(viol), 32'd0);
    cyc(0, 0, 1, 0, '0, '0, 16'h0052, 4'd1);
    expect_viol("R6 younger removed", 1'b0, '0);

    // R6 finish in the violation cycle is discarded
    cyc(1, 0, 0, 0, 16'h0060, 4'd6, '0, '0);
    cyc(1, 0, 1, 0, 16'h0060, 4'd7, 16'h0060, 4'd5);
    expect_viol("R6 viol", 1'b1, 4'd6);
    cyc(0, 0, 1, 0, '0, '0, 16'h0060, 4'd5);
    expect_viol("R6 concurrent finish dropped", 1'b0, '0);

    // R9 flush suppresses same-cycle store check
    cyc(1, 0, 0, 0, 16'h0070, 4'd3, '0, '0);
    cyc(0, 0, 1, 1, '0, '0, 16'h0070, 4'd1);
    expect_viol("R9 flush suppress", 1'b0, '0);
    cyc(0, 0, 1, 0, '0, '0, 16'h0070, 4'd1);
    expect_viol("R9 flush empties", 1'b0, '0);

    // R7 complete on empty queue has no effect
    cyc(0, 1, 0, 0, '0, '0, '0, '0);
    cyc(1, 0, 0, 0, 16'h0080, 4'd5, '0, '0);
    cyc(0, 0, 1, 0, '0, '0, 16'h0080, 4'd4);
    expect_viol("R7 empty complete ignored", 1'b1, 4'd5);
    chk("R1 ready at end", 32'(ready), 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule